// File: doc/BRIEF.md
# Mesh Router Input Port with XY Routing and Backpressure

This block is one input port of a five-port wormhole router in a two-dimensional mesh. Flits arrive from the upstream link and are stored in a first-in first-out buffer whose depth is a parameter. The port never drops a flit that arrives with room available. It raises a nearly-full flag early enough that a flit already on the wire still finds space.

The flit at the front of the buffer carries a destination X and Y coordinate. The port compares these coordinates with the router's own position, which is set by parameters, and picks one output direction with dimension-ordered routing. X is resolved first, then Y. The port presents the result to the switch allocator as a one-hot five-bit request.

When the allocator grants, the front flit is dequeued onto the output bus. Once a packet's first flit has left, its direction is held, and every later flit of the packet follows it, whatever those flits carry in their header bits. A tail flit releases the held direction. When a tail flit leaves, the port pulses a marker so that the allocator can free the output.

Top module: `mesh_inport`

## Requirements
- R1: After a synchronous active-high reset the buffer is empty: `req` is 0, `nearly_full` is 0 and `tail_sent` is 0.
- R2: Stored flits appear on `out_flit` in arrival order, and one flit leaves on each clock edge where `grant` is high and `req` is nonzero.
- R3: A flit offered while DEPTH flits are stored is discarded. Neither the stored flits nor their order change.
- R4: `nearly_full` is high exactly when the number of stored flits is at least DEPTH-1.
- R5: Flit field positions: bits 7:0 payload, bit 8 tail marker, bit 9 head marker, bits 12:10 destination X, bits 15:13 destination Y, bits 19:16 spare header bits.
- R6: `req` is one-hot, with bit 0 Local, bit 1 North, bit 2 South, bit 3 East and bit 4 West. If the destination X is greater than LOC_X the request is East, and if it is less the request is West. Otherwise, if the destination Y is greater than LOC_Y the request is North, and if it is less the request is South. Otherwise it is Local.
- R7: After a flit without the tail marker is dequeued while no route is held, that flit's direction is held. `req` shows the held direction for every following flit, whatever their header bits are, until a flit with the tail marker is dequeued.
- R8: `req` is 0 whenever the buffer is empty, and a `grant` with `req` at 0 changes nothing.
- R9: `tail_sent` is high for exactly the one cycle after each clock edge that dequeues a flit carrying the tail marker.
- R10: DEPTH is a power of two from 4 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream offers `in_flit` this cycle |
| in_flit | input | 20 | Incoming flit |
| nearly_full | output | 1 | Backpressure toward the upstream sender |
| req | output | 5 | One-hot output-direction request to the switch allocator |
| grant | input | 1 | Allocator grant; dequeues the front flit |
| out_flit | output | 20 | Front flit of the buffer |
| tail_sent | output | 1 | Pulse after a tail flit has been dequeued |

## Verification
A corrupted buffer pointer or count shows up on `out_flit` or `nearly_full` at the first comparison after the faulty edge, because the bench compares every cycle against a queue model. A held route that is not cleared or not set changes `req` on the very next flit of the packet. The body flits carry random coordinates on purpose, so a port that re-routes them gives a different direction almost at once. A lost or late tail marker shows one cycle after the dequeuing edge.

// File: rtl/mesh_inport_pkg.sv
package mesh_inport_pkg;
  localparam int FLIT_W   = 20;
  localparam int COORD_W  = 3;
  localparam int NPORT    = 5;
  localparam int TAIL_BIT = 8;
  localparam int HEAD_BIT = 9;
  localparam int DX_LSB   = 10;
  localparam int DY_LSB   = 13;
  // one-hot request bit positions
  localparam int DIR_LOCAL = 0;
  localparam int DIR_NORTH = 1;
  localparam int DIR_SOUTH = 2;
  localparam int DIR_EAST  = 3;
  localparam int DIR_WEST  = 4;
endpackage

// File: rtl/flit_fifo.sv
module flit_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [$clog2(DEPTH):0] count,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  // storage without reset so the array maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: a full buffer with no dequeue stays full and does not grow
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> (full && $stable(wr_ptr)));

  // R2: pointers move only when an entry is taken or stored
  p_rd_move_r2: assert property (@(posedge clk) disable iff (rst)
    (!pop || empty) |=> $stable(rd_ptr));
endmodule

// File: rtl/xy_route.sv
module xy_route
  import mesh_inport_pkg::*;
#(
  parameter int LOC_X = 1,
  parameter int LOC_Y = 1
) (
  input  logic [FLIT_W-1:0] flit,
  output logic [NPORT-1:0]  dir
);
  localparam logic [COORD_W-1:0] MY_X = COORD_W'(LOC_X);
  localparam logic [COORD_W-1:0] MY_Y = COORD_W'(LOC_Y);

  logic [COORD_W-1:0] dx, dy;
  assign dx = flit[DX_LSB +: COORD_W];
  assign dy = flit[DY_LSB +: COORD_W];

  always_comb begin
    dir = '0;
    if (dx > MY_X)      dir[DIR_EAST]  = 1'b1;
    else if (dx < MY_X) dir[DIR_WEST]  = 1'b1;
    else if (dy > MY_Y) dir[DIR_NORTH] = 1'b1;
    else if (dy < MY_Y) dir[DIR_SOUTH] = 1'b1;
    else                dir[DIR_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/route_hold.sv
module route_hold
  import mesh_inport_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pop,
  input  logic             pop_tail,
  input  logic [NPORT-1:0] fresh_dir,
  output logic [NPORT-1:0] held_dir,
  output logic             locked,
  output logic             tail_sent
);
  always_ff @(posedge clk) begin
    if (rst) begin
      locked    <= 1'b0;
      held_dir  <= '0;
      tail_sent <= 1'b0;
    end else begin
      tail_sent <= pop & pop_tail;
      if (pop) begin
        if (pop_tail) begin
          locked   <= 1'b0;
          held_dir <= '0;
        end else if (!locked) begin
          locked   <= 1'b1;
          held_dir <= fresh_dir;
        end
      end
    end
  end

  // R7: a held route does not change until a tail leaves
  p_lock_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (locked && !(pop && pop_tail)) |=> (locked && $stable(held_dir)));

  // R9: the tail marker follows a dequeue of a tail flit
  p_tail_cause_r9: assert property (@(posedge clk) disable iff (rst)
    (pop && pop_tail) |=> tail_sent);
endmodule

// File: rtl/mesh_inport.sv
module mesh_inport
  import mesh_inport_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LOC_X = 2,
  parameter int LOC_Y = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              nearly_full,
  output logic [NPORT-1:0]  req,
  input  logic              grant,
  output logic [FLIT_W-1:0] out_flit,
  output logic              tail_sent
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0]    count;
  logic             full, empty, pop, locked;
  logic [NPORT-1:0] fresh_dir, held_dir;

  flit_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(in_valid), .din(in_flit),
    .pop(pop), .dout(out_flit), .count(count), .full(full), .empty(empty)
  );

  xy_route #(.LOC_X(LOC_X), .LOC_Y(LOC_Y)) u_route (
    .flit(out_flit), .dir(fresh_dir)
  );

  route_hold u_hold (
    .clk(clk), .rst(rst), .pop(pop), .pop_tail(out_flit[TAIL_BIT]),
    .fresh_dir(fresh_dir), .held_dir(held_dir), .locked(locked),
    .tail_sent(tail_sent)
  );

  assign pop         = grant & ~empty;
  assign req         = empty ? '0 : (locked ? held_dir : fresh_dir);
  assign nearly_full = (count >= CW'(DEPTH - 1));

  initial begin
    p_depth_r10: assert (DEPTH >= 4 && DEPTH <= 32 && (DEPTH & (DEPTH - 1)) == 0);
  end

  // R6: never more than one direction requested
  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req));

  // R8: an empty buffer requests nothing
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    empty |-> (req == '0));

  // R4: backpressure can only rise after a flit was offered
  p_nf_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(nearly_full) |-> $past(in_valid));
endmodule

// File: tb/mesh_inport_test.sv
module mesh_inport_test;
  localparam int DEPTH = 8;
  localparam int LX = 2;
  localparam int LY = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [19:0] in_flit;
  logic        nearly_full;
  logic [4:0]  req;
  logic        grant;
  logic [19:0] out_flit;
  logic        tail_sent;

  int checks = 0;
  int fails  = 0;

  logic [19:0] q[$];
  logic        locked = 1'b0;
  logic [4:0]  lroute = '0;
  logic        exp_tail = 1'b0;
  int          pkt_left = 0;

  always #10 clk = ~clk;

  mesh_inport #(.DEPTH(DEPTH), .LOC_X(LX), .LOC_Y(LY)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
    .nearly_full(nearly_full), .req(req), .grant(grant),
    .out_flit(out_flit), .tail_sent(tail_sent)
  );

  // R6 expected direction from coordinates (R5 field positions)
  function automatic logic [4:0] xy_dir(input logic [19:0] f);
    int dx, dy;
    dx = int'(f[12:10]);
    dy = int'(f[15:13]);
    if (dx > LX) return 5'b01000;
    if (dx < LX) return 5'b10000;
    if (dy > LY) return 5'b00010;
    if (dy < LY) return 5'b00100;
    return 5'b00001;
  endfunction

  function automatic logic [4:0] exp_req();
    if (q.size() == 0) return 5'b0;
    if (locked) return lroute;
    return xy_dir(q[0]);
  endfunction

  function automatic logic [19:0] mk(input int dx, input int dy,
                                     input logic hd, input logic tl);
    logic [19:0] f;
    f = $urandom;
    f[12:10] = 3'(dx);
    f[15:13] = 3'(dy);
    f[9] = hd;
    f[8] = tl;
    return f;
  endfunction

  function automatic logic [19:0] gen_flit();
    logic [19:0] f;
    int len;
    if (pkt_left == 0) begin
      len = 1 + int'($urandom % 4);
      f = mk(int'($urandom % 8), int'($urandom % 8), 1'b1, len == 1);
      pkt_left = len - 1;
    end else begin
      f = mk(int'($urandom % 8), int'($urandom % 8), 1'b0, pkt_left == 1);
      pkt_left = pkt_left - 1;
    end
    return f;
  endfunction

  task automatic chk(input logic ok, input string what,
                     input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic compare();
    logic [4:0] er;
    er = exp_req();
    chk(req == er, "R6 R7 R8 req", 20'(req), 20'(er));
    chk(nearly_full == (q.size() >= DEPTH - 1), "R4 nearly_full",
        20'(nearly_full), 20'(q.size() >= DEPTH - 1));
    chk(tail_sent == exp_tail, "R9 tail_sent", 20'(tail_sent), 20'(exp_tail));
    if (q.size() > 0)
      chk(out_flit == q[0], "R2 R3 out_flit", out_flit, q[0]);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic v, input logic [19:0] f, input logic g);
    logic acc;
    logic [19:0] f0;
    compare();
    in_valid = v;
    in_flit  = f;
    grant    = g;
    acc = v && (q.size() < DEPTH);
    @(posedge clk);
    exp_tail = 1'b0;
    if (g && q.size() > 0) begin
      f0 = q.pop_front();
      exp_tail = f0[8];
      if (f0[8]) locked = 1'b0;
      else if (!locked) begin
        locked = 1'b1;
        lroute = xy_dir(f0);
      end
    end
    if (acc) q.push_back(f);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_flit = '0; grant = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(req == 5'b0 && !nearly_full && !tail_sent, "R1 reset outputs",
        {13'b0, req, nearly_full, tail_sent}, 20'b0);

    // R6 single-flit packets to each direction, plus R8 grant with empty buffer
    step(1'b0, '0, 1'b1);
    step(1'b1, mk(5, 0, 1, 1), 1'b0);   // East
    step(1'b0, '0, 1'b1);
    step(1'b1, mk(0, 7, 1, 1), 1'b0);   // West
    step(1'b0, '0, 1'b1);
    step(1'b1, mk(LX, 7, 1, 1), 1'b0);  // North
    step(1'b0, '0, 1'b1);
    step(1'b1, mk(LX, 0, 1, 1), 1'b0);  // South
    step(1'b0, '0, 1'b1);
    step(1'b1, mk(LX, LY, 1, 1), 1'b0); // Local
    step(1'b0, '0, 1'b1);

    // R7 wormhole: head East, body flits with Local/West coordinates
    step(1'b1, mk(7, 0, 1, 0), 1'b0);
    step(1'b1, mk(LX, LY, 0, 0), 1'b0);
    step(1'b1, mk(0, 0, 0, 1), 1'b0);
    step(1'b1, mk(LX, LY, 1, 1), 1'b0);
    repeat (5) step(1'b0, '0, 1'b1);

    // R3 R4 overflow: offer DEPTH+3 flits, never grant, then drain
    pkt_left = 0;
    for (int i = 0; i < DEPTH + 3; i++) step(1'b1, gen_flit(), 1'b0);
    chk(nearly_full, "R3 R4 full buffer flags", 20'(nearly_full), 20'd1);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, '0, 1'b1);
    // leftover partial packet may hold a route; finish it with a tail
    step(1'b1, mk(LX, LY, 1, 1), 1'b0);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);

    // R2 R4 R6 R7 R9 constrained random with backpressure honoured
    pkt_left = 0;
    for (int i = 0; i < 4000; i++) begin
      logic v;
      v = ($urandom % 4 != 0) && !(q.size() >= DEPTH - 1);
      step(v, v ? gen_flit() : 20'b0, ($urandom % 3) != 0);
    end
    repeat (DEPTH + 2) step(1'b0, '0, 1'b1);
    compare();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule